// File: doc/BRIEF.md
# Periodic interrupt rate generator

This block derives a periodic interrupt from a 32.768 kHz time base. The time base arrives as a one-cycle enable on the system clock. Each enable advances a free-running 15-bit count. A 4-bit rate code, held in a register elsewhere, selects a power-of-two period. A tick fires whenever the count lands on a multiple of that period. Ticks therefore stay phase-locked to the free-running count, not to the moment the code was written.

Each tick sets a sticky periodic flag, which is held until a clear strobe arrives. Each tick also issues a one-cycle request to raise the shared interrupt-request flag. The generator runs only while the rate code is non-zero and the periodic-interrupt-enable input is high.

Top module: `periodic_rate_gen`

## Requirements
- R1: The free-running count is 15 bits wide, starts at 0 after reset, advances by one on each cycle with `tb_en` high, holds otherwise, and wraps from 32767 to 0 without disturbing tick alignment.
- R2: A rate code of 0 produces no tick, no flag and no request.
- R3: Rate codes 1 and 2 behave as codes 8 and 9, giving periods of 128 and 256 time-base cycles.
- R4: For an effective code n in the range 3 to 15, `tick` pulses for one cycle, one clock after an enabled time-base cycle that brings the count to a multiple of 2^(n-1).
- R5: While `pie` is low, no tick fires, and neither the flag nor the request is set.
- R6: `pflag` rises together with `tick` and stays high until a cycle with `flag_clr` high and no tick. A tick in the same cycle as the clear leaves the flag set.
- R7: `irq_req` is a one-cycle pulse coinciding with `tick`, issued only when `pie` was high.
- R8: After a change of rate code, the next tick comes at the next multiple of the new period counted from the current free-running count.
- R9: During and right after reset, `tick`, `pflag` and `irq_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_en | input | 1 | One-cycle enable per 32.768 kHz time-base cycle |
| rate_sel | input | 4 | Rate code; 0 stops the generator |
| pie | input | 1 | Periodic-interrupt enable |
| flag_clr | input | 1 | Clears the sticky flag |
| tick | output | 1 | One-cycle pulse at each period boundary |
| pflag | output | 1 | Sticky periodic flag |
| irq_req | output | 1 | Request to raise the shared interrupt-request flag |

## Verification
All three outputs are registered. They reflect the inputs presented in the cycle of the clock edge just before they are observed. The bench drives each stimulus on the falling edge and advances its own model of the count at the same moment. It compares `tick`, `pflag` and `irq_req` 1 ns after the following rising edge, so each result is checked exactly one cycle after its stimulus. Long constant-rate stretches are also checked by tick totals computed in closed form from the starting count and the period. This covers aliasing, rate changes and counter wrap without reference to the per-cycle model.

// File: rtl/periodic_rate_gen.sv
module periodic_rate_gen #(
  parameter int CNT_W  = 15,
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tb_en,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              pie,
  input  logic              flag_clr,
  output logic              tick,
  output logic              pflag,
  output logic              irq_req
);
  localparam int ALIAS_LIMIT = 3;
  localparam int ALIAS_ADD   = 7;

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cnt_nxt;
  logic [RATE_W-1:0] eff;
  logic [CNT_W-1:0]  mask;
  logic              running;
  logic              hit;

  assign eff = (rate_sel != '0 && rate_sel < RATE_W'(ALIAS_LIMIT))
             ? rate_sel + RATE_W'(ALIAS_ADD) : rate_sel;
  assign mask    = ~({CNT_W{1'b1}} << (eff - RATE_W'(1)));
  assign running = (eff != '0) && pie;
  assign cnt_nxt = cnt + CNT_W'(1);
  assign hit     = tb_en && running && ((cnt_nxt & mask) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      tick    <= 1'b0;
      pflag   <= 1'b0;
      irq_req <= 1'b0;
    end else begin
      if (tb_en) cnt <= cnt_nxt;
      tick    <= hit;
      irq_req <= hit && pie;
      pflag   <= hit || (pflag && !flag_clr);
    end
  end
endmodule

// File: rtl/periodic_rate_gen_chk.sv
module periodic_rate_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tb_en,
  input logic [3:0] rate_sel,
  input logic       pie,
  input logic       flag_clr,
  input logic       tick,
  input logic       pflag,
  input logic       irq_req
);
  p_code0_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rate_sel) == 4'd0 |-> !tick);

  p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  p_tick_needs_pie_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(pie) && $past(tb_en));

  p_tick_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> pflag);

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pflag) && !$past(flag_clr)) |-> pflag);

  p_irq_with_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> tick && $past(pie));
endmodule

bind periodic_rate_gen periodic_rate_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .rate_sel(rate_sel), .pie(pie),
  .flag_clr(flag_clr), .tick(tick), .pflag(pflag), .irq_req(irq_req)
);

// File: tb/periodic_rate_gen_test.sv
module periodic_rate_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tb_en = 1'b0;
  logic [3:0] rate_sel = 4'd0;
  logic       pie = 1'b0;
  logic       flag_clr = 1'b0;
  logic       tick, pflag, irq_req;

  int checks = 0;
  int failures = 0;
  logic [14:0] m_cnt = '0;
  longint      m_abs = 0;
  bit          e_tick = 0, e_flag = 0, e_irq = 0;
  int          nticks = 0;

  always #4 clk = ~clk;

  periodic_rate_gen uut (
    .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .rate_sel(rate_sel), .pie(pie),
    .flag_clr(flag_clr), .tick(tick), .pflag(pflag), .irq_req(irq_req)
  );

  function automatic int eff_code(int r);
    if (r == 0) return 0;
    if (r < 3) return r + 7;
    return r;
  endfunction

  function automatic longint period_of(int r);
    return longint'(1) << (eff_code(r) - 1);
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(bit en, int r, bit p, bit c, string tag);
    int e;
    @(negedge clk);
    tb_en = en; rate_sel = 4'(r); pie = p; flag_clr = c;
    e = eff_code(r);
    if (en) begin m_cnt = m_cnt + 15'd1; m_abs++; end
    e_tick = en && p && e != 0 && ((int'(m_cnt) % (1 << (e - 1))) == 0);
    e_irq  = e_tick && p;
    e_flag = e_tick || (e_flag && !c);
    @(posedge clk); #1;
    check({tag, " R4 tick"}, tick, e_tick);
    check({tag, " R7 irq_req"}, irq_req, e_irq);
    check({tag, " R6 pflag"}, pflag, e_flag);
    if (tick) nticks++;
  endtask

  task automatic run_const(int n, int r, bit p, string tag);
    longint c0, per, exp;
    c0 = m_abs; nticks = 0;
    for (int i = 0; i < n; i++) step(1'b1, r, p, 1'b0, tag);
    per = period_of(r);
    exp = (eff_code(r) == 0 || !p) ? 0 : ((c0 + n) / per - c0 / per);
    check({tag, " tick total"}, nticks, exp);
  endtask

  initial begin
    #(8 * 200000);
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset tick", tick, 0);
    check("R9 reset pflag", pflag, 0);
    check("R9 reset irq_req", irq_req, 0);
    rst_n = 1'b1;

    run_const(20, 3, 1, "R4 code3");
    run_const(64, 5, 1, "R4 code5");
    for (int i = 0; i < 24; i++) step(1'b1, 3, 1, 1'b1, "R6 clear_vs_tick");
    step(1'b0, 3, 1, 1'b1, "R6 clear");
    check("R6 flag cleared", pflag, 0);
    run_const(40, 0, 1, "R2 code0");
    run_const(40, 3, 0, "R5 pie_off");
    check("R5 flag stays low", pflag, 0);
    run_const(600, 1, 1, "R3 code1");
    run_const(600, 2, 1, "R3 code2");
    for (int i = 0; i < 300; i++) step(1'($urandom % 2), 4, 1, 1'b0, "R1 en_gating");
    run_const(10, 6, 1, "R8 before");
    run_const(13, 3, 1, "R8 after_change");
    run_const(21, 7, 1, "R8 slower");
    run_const(33000, 15, 1, "R1 wrap");

    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 3000; i++)
      step(1'($urandom % 4 != 0), int'($urandom % 16), 1'($urandom % 8 != 0),
           1'($urandom % 5 == 0), "R4 random");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule